// File: doc/BRIEF.md
# Mains Edge Conditioner and Seconds Divider

This block takes a slow, noisy digital line derived from 60 Hz mains and turns it into a clean level that counting logic can rely on. It then reduces that level to a seconds tick and a small running count of seconds. A fast system clock runs the whole block. The raw line is never used as a clock.

The raw input first passes through a synchronizer. It then drives a single state bit through set and clear conditions that depend on a qualifier. The qualifier is a delayed copy of the state bit itself. After any change of the state bit, a down-counter is reloaded. The qualifier only catches up with the state bit once that counter has run out. Until then the state bit cannot move back, so glitches and chatter on slow edges are absorbed without any analog hysteresis. Each rising edge of the clean level is counted. Every sixtieth edge produces a one-cycle tick and advances a seconds counter that wraps.

Top module: `mains_cond`

## Requirements
- R1: While rst_ni is low, and on the first clock after it is released, clean_o, tick_o and sec_o are all 0. Reset also clears the lockout, so the first raw rise after reset is followed as described in R2.
- R2: Outside a lockout, a level change on raw_i that persists appears on clean_o at the third rising clock edge after raw_i changes (two synchronizer stages, then the state bit). This holds for rising and falling levels.
- R3: After any change of clean_o, clean_o keeps its new value for at least DELAY_CYCLES+1 clock cycles, whatever raw_i does.
- R4: A pulse of the opposite level on raw_i that starts and ends within the lockout after a transition changes neither clean_o nor the counts.
- R5: A raw level opposite to clean_o that persists past the end of the lockout is adopted by clean_o.
- R6: Each rising edge of clean_o advances an internal divide count. The edge that completes a group of DIV_RATIO (default 60) rising edges raises tick_o and increments sec_o by one.
- R7: tick_o is high for exactly one clock cycle per group of DIV_RATIO rising edges.
- R8: sec_o is SEC_W bits wide (default 4) and wraps from 15 to 0 on the tick that follows 15.
- R9: The divide count wraps from DIV_RATIO-1 to 0, so every later group of exactly DIV_RATIO clean rising edges produces exactly one further tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Raw mains-derived line, asynchronous to clk_i |
| clean_o | output | 1 | Conditioned level (the state bit) |
| tick_o | output | 1 | One-cycle pulse once every DIV_RATIO clean rising edges |
| sec_o | output | SEC_W | Count of elapsed ticks, wrapping |

## Verification
The assertions assume that the delay parameter is at least one cycle, and that clean_o never produces two rising edges closer together than two lockout intervals. This is what keeps tick_o a lone pulse. They assume nothing about the raw line itself, which may toggle on any cycle. The stimulus drives raw_i only at falling clock edges. It holds each half-period of the 60 Hz line well beyond the lockout. Glitches are injected only within the lockout window that follows a transition, so every expected level and count follows from the stated latency and interval.

// File: rtl/mains_pkg.sv
package mains_pkg;
  parameter int unsigned DEF_CLK_HZ   = 250_000_000;
  parameter int unsigned DEF_DIV      = 60;
  parameter int unsigned DEF_SEC_W    = 4;
  parameter int unsigned DEF_SYNC_LEN = 2;
endpackage

// File: rtl/mc_sync.sv
module mc_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b0;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/mc_edge_qual.sv
module mc_edge_qual #(
  parameter int unsigned DELAY_CYCLES = 250_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic state_o
);
  localparam int unsigned DW       = $clog2(DELAY_CYCLES + 1);
  localparam int unsigned HOLD_MAX = DELAY_CYCLES + 1;
  localparam int unsigned HW       = $clog2(HOLD_MAX + 1);

  logic          state_q, state_n, qual_q;
  logic [DW-1:0] dly_q;

  // set/clear only against the delayed copy of the state bit
  always_comb begin
    state_n = state_q;
    if (raw_i && !qual_q)      state_n = 1'b1;
    else if (!raw_i && qual_q) state_n = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= 1'b0;
      qual_q  <= 1'b0;
      dly_q   <= '0;
    end else begin
      state_q <= state_n;
      if (state_n != state_q)  dly_q <= DW'(DELAY_CYCLES);
      else if (dly_q != '0)    dly_q <= dly_q - 1'b1;
      if (dly_q == '0)         qual_q <= state_q;
    end
  end

  assign state_o = state_q;

  // checker: cycles since last change of the state bit
  logic          state_p;
  logic [HW-1:0] hold_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_p <= 1'b0;
      hold_q  <= HW'(HOLD_MAX);
    end else begin
      state_p <= state_q;
      if (state_q != state_p)        hold_q <= '0;
      else if (hold_q != HW'(HOLD_MAX)) hold_q <= hold_q + 1'b1;
    end
  end

  a_r3_min_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != state_p) |-> (hold_q == HW'(HOLD_MAX)));

  a_r4_change_needs_qual: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != $past(state_q)) |-> ($past(qual_q) == $past(state_q)));
endmodule

// File: rtl/mc_div.sv
module mc_div #(
  parameter int unsigned DIV_RATIO = 60,
  parameter int unsigned SEC_W     = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_i,
  output logic             tick_o,
  output logic [SEC_W-1:0] sec_o
);
  localparam int unsigned CW = $clog2(DIV_RATIO);

  logic [CW-1:0]    div_q;
  logic [SEC_W-1:0] sec_q;
  logic             tick_q;
  logic             last_w;

  assign last_w = (div_q == CW'(DIV_RATIO - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      sec_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= ev_i && last_w;
      if (ev_i) begin
        if (last_w) begin
          div_q <= '0;
          sec_q <= sec_q + 1'b1;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign tick_o = tick_q;
  assign sec_o  = sec_q;

  a_r7_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);

  a_r6_sec_moves_with_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_q != $past(sec_q)) |-> tick_q);

  a_r8_sec_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_q && $past(sec_q) == {SEC_W{1'b1}}) |-> (sec_q == '0));
endmodule

// File: rtl/mains_cond.sv
module mains_cond
  import mains_pkg::*;
#(
  parameter int unsigned CLK_HZ       = DEF_CLK_HZ,
  parameter int unsigned DELAY_CYCLES = CLK_HZ / 1000,
  parameter int unsigned DIV_RATIO    = DEF_DIV,
  parameter int unsigned SEC_W        = DEF_SEC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  output logic             clean_o,
  output logic             tick_o,
  output logic [SEC_W-1:0] sec_o
);
  logic raw_s, state_w, state_d, rise_w;

  mc_sync #(.STAGES(DEF_SYNC_LEN)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_i),
    .q_o   (raw_s)
  );

  mc_edge_qual #(.DELAY_CYCLES(DELAY_CYCLES)) i_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_s),
    .state_o(state_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) state_d <= 1'b0;
    else         state_d <= state_w;

  assign rise_w = state_w && !state_d;

  mc_div #(.DIV_RATIO(DIV_RATIO), .SEC_W(SEC_W)) i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ev_i  (rise_w),
    .tick_o(tick_o),
    .sec_o (sec_o)
  );

  assign clean_o = state_w;

  a_r1_reset_quiet: assert property (@(posedge clk_i)
    !rst_ni |=> (!clean_o && !tick_o));
endmodule

// File: tb/test_mains_cond.sv
`timescale 1ns/1ps
module test_mains_cond;
  localparam int unsigned DLY = 8;
  localparam int unsigned DIV = 60;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       raw = 1'b0;
  logic       clean, tick;
  logic [3:0] sec;

  int total = 0, bad = 0;
  int tick_cnt = 0, rise_cnt = 0, dbl_tick = 0;
  logic prev_clean = 1'b0, prev_tick = 1'b0;

  always #2 clk = ~clk;

  mains_cond #(.CLK_HZ(8000), .DELAY_CYCLES(DLY), .DIV_RATIO(DIV), .SEC_W(4)) i_mains_cond (
    .clk_i(clk), .rst_ni(rst_n), .raw_i(raw),
    .clean_o(clean), .tick_o(tick), .sec_o(sec)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (tick) tick_cnt++;
      if (tick && prev_tick) dbl_tick++;
      if (clean && !prev_clean) rise_cnt++;
    end
    prev_tick  <= tick;
    prev_clean <= clean;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      raw = 1'b1; cyc(20);
      raw = 1'b0; cyc(20);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; raw = 1'b0;
    #1;
    check(clean == 0 && tick == 0 && sec == 0, "R1 async clear", {clean, tick, sec}, 0);
    cyc(3); rst_n = 1'b1; cyc(1);
    check(clean == 0 && tick == 0 && sec == 0, "R1 after release", {clean, tick, sec}, 0);
    tick_cnt = 0; rise_cnt = 0;
  endtask

  task automatic t_latency();
    cyc(30);
    raw = 1'b1;
    cyc(2);
    check(clean == 1'b0, "R2 rise not early", clean, 0);
    cyc(1);
    check(clean == 1'b1, "R2 rise at third edge", clean, 1);
    cyc(30);
    raw = 1'b0;
    cyc(2);
    check(clean == 1'b1, "R2 fall not early", clean, 1);
    cyc(1);
    check(clean == 1'b0, "R2 fall at third edge", clean, 0);
    cyc(30);
  endtask

  task automatic t_lockout();
    int r0, bad_seen;
    r0 = rise_cnt;
    raw = 1'b1; cyc(4);
    check(clean == 1'b1, "R2 rise seen", clean, 1);
    raw = 1'b0; bad_seen = 0;
    for (int i = 0; i < 4; i++) begin cyc(1); if (!clean) bad_seen++; end
    raw = 1'b1;
    for (int i = 0; i < 20; i++) begin cyc(1); if (!clean) bad_seen++; end
    check(bad_seen == 0, "R3 R4 hold after rise", bad_seen, 0);
    check(rise_cnt == r0 + 1, "R4 glitch not counted", rise_cnt - r0, 1);
    raw = 1'b0; cyc(4);
    check(clean == 1'b0, "R5 long low adopted", clean, 0);
    raw = 1'b1; bad_seen = 0;
    for (int i = 0; i < 3; i++) begin cyc(1); if (clean) bad_seen++; end
    raw = 1'b0;
    for (int i = 0; i < 20; i++) begin cyc(1); if (clean) bad_seen++; end
    check(bad_seen == 0, "R3 R4 hold after fall", bad_seen, 0);
    check(rise_cnt == r0 + 1, "R4 fall glitch not counted", rise_cnt - r0, 1);
    // late low: raw stays opposite across end of lockout
    raw = 1'b1; cyc(4);
    raw = 1'b0; cyc(DLY + 6);
    check(clean == 1'b0, "R5 level adopted after lockout", clean, 0);
    cyc(20);
  endtask

  task automatic t_count();
    do_reset();
    pulses(DIV - 1);
    check(tick_cnt == 0 && sec == 0, "R6 no tick before group end", tick_cnt, 0);
    pulses(1);
    check(tick_cnt == 1, "R6 tick on sixtieth edge", tick_cnt, 1);
    check(sec == 1, "R6 sec increments", sec, 1);
    pulses(DIV);
    check(tick_cnt == 2 && sec == 2, "R9 divide count wraps", tick_cnt, 2);
    check(dbl_tick == 0, "R7 tick single cycle", dbl_tick, 0);
  endtask

  task automatic t_wrap();
    pulses(13 * DIV);
    check(sec == 15, "R8 sec reaches 15", sec, 15);
    pulses(DIV);
    check(sec == 0, "R8 sec wraps to 0", sec, 0);
    check(tick_cnt == 16, "R7 one tick per group", tick_cnt, 16);
    check(dbl_tick == 0, "R7 no double tick", dbl_tick, 0);
  endtask

  task automatic t_reset_mid();
    pulses(DIV + 10);
    check(sec == 1, "R6 sec before reset", sec, 1);
    do_reset();
    pulses(DIV - 1);
    check(sec == 0, "R1 divide count cleared", sec, 0);
    pulses(1);
    check(sec == 1, "R1 full group after reset", sec, 1);
  endtask

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    check(clean == 0 && tick == 0 && sec == 0, "R1 reset state", {clean, tick, sec}, 0);
    t_latency();
    t_lockout();
    t_count();
    t_wrap();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 190_000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule